// File: doc/BRIEF.md
# Oscillator Activity Monitor

This block watches two external oscillator lines from a free-running reference clock and gives each line a three-way verdict: stuck low, stuck high, or toggling. It tells a missing oscillator or a shorted pin apart from a live clock. The block does not measure frequency. It is meant to feed a two-character status field, so each verdict is also given as an 8-bit character code.

Each oscillator line first passes through its own two-flop synchronizer into the reference domain. A rising-edge detector sits after the synchronizer, and a saturating counter counts the edges it reports. A window controller runs a fixed observation window and has two named states:

- `WIN_OBSERVE` counts through every cycle of the window except the last. It moves to `WIN_CLOSE` when its timer reaches the second-to-last count.
- `WIN_CLOSE` lasts one cycle, the last one of the window. It always returns to `WIN_OBSERVE` with the timer cleared.

Each channel keeps its verdict in a three-state machine whose states are `ACT_STUCK_LO`, `ACT_STUCK_HI` and `ACT_TOGGLING`. The verdict moves only in the `WIN_CLOSE` cycle:

- It moves to `ACT_TOGGLING` if the window saw enough rising edges.
- Otherwise it moves to `ACT_STUCK_HI` or `ACT_STUCK_LO`, following the synchronized level at that moment.

With the default settings, the reference clock is an on-board 27 MHz oscillator and the monitored clocks run between 1 MHz and 10 MHz. The default window is 4096 reference cycles, so even a 1 MHz input gives well over a hundred edges per window.

Top module: `osc_activity_monitor`

## Requirements
- R1: The two oscillator inputs are judged independently. Each has its own status and character outputs, and activity on one never changes the other's verdict.
- R2: The status encoding is 2'b00 for stuck low, 2'b01 for stuck high and 2'b10 for toggling. The value 2'b11 never appears.
- R3: A channel reads 2'b10 (toggling) after a window in which its synchronized input showed at least EDGE_MIN rising edges (4 by default).
- R4: A channel that saw fewer than EDGE_MIN rising edges in a window reads the synchronized level at the window's last cycle: 2'b01 if that level is high, 2'b00 if it is low.
- R5: A window lasts 2^WIN_LOG2 reference cycles. Verdicts change only at the rising edge that ends a window, and the first such edge is the 2^WIN_LOG2-th rising edge after reset is released.
- R6: From reset until the first window ends, both statuses read 2'b00 and both character outputs read 8'h19.
- R7: The character output for each channel is 8'h19 (down arrow) when stuck low, 8'h18 (up arrow) when stuck high, and 8'h12 (up-down arrow) when toggling.
- R8: Each input passes two synchronizer flops before edge detection. An edge counts toward a window only if the rising edge after its detection falls within that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_ref |
| osc_a | input | 1 | First monitored oscillator line (asynchronous) |
| osc_b | input | 1 | Second monitored oscillator line (asynchronous) |
| stat_a | output | 2 | Verdict for osc_a |
| stat_b | output | 2 | Verdict for osc_b |
| glyph_a | output | 8 | Character code for osc_a's verdict |
| glyph_b | output | 8 | Character code for osc_b's verdict |

## Verification
The bench uses a 64-cycle window, aligned to the cycle count since reset, and sweeps the number of complete pulses from zero to six. For each count it ends the window with the line left low and with it left high. The final rise then adds an edge, so the edge total crosses the threshold at different pulse counts, and the sweep separates the edge-count rule from the level rule. The second input gets the mirrored pattern in the same window, so a crossed channel or a shared counter shows as a wrong verdict on one side. Before each window ends, the outputs are read one cycle early to confirm that the previous verdict still holds. The reset window is read twice to pin down when the first update happens.

// File: rtl/oscmon_pkg.sv
package oscmon_pkg;

    // Per-channel verdict; the encoding is visible on the ports.
    typedef enum logic [1:0] {
        ACT_STUCK_LO = 2'b00,
        ACT_STUCK_HI = 2'b01,
        ACT_TOGGLING = 2'b10
    } act_state_e;

    // Observation window controller states.
    typedef enum logic {
        WIN_OBSERVE = 1'b0,
        WIN_CLOSE   = 1'b1
    } win_state_e;

endpackage

// File: rtl/oscmon_sync.sv
module oscmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;

    // Two reported edges can never be adjacent.
    assert_no_double_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/oscmon_window.sv
module oscmon_window
    import oscmon_pkg::*;
#(
    parameter int WIN_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic close
);
    localparam int WIN_CYCLES = 1 << WIN_LOG2;
    localparam int TIMER_W    = WIN_LOG2;
    localparam logic [TIMER_W-1:0] LAST_OBS = TIMER_W'(WIN_CYCLES - 2);

    win_state_e         state_q, state_d;
    logic [TIMER_W-1:0] timer_q, timer_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_OBSERVE;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        unique case (state_q)
            WIN_OBSERVE: begin
                timer_d = timer_q + 1'b1;
                if (timer_q == LAST_OBS) state_d = WIN_CLOSE;
            end
            WIN_CLOSE: begin
                timer_d = '0;
                state_d = WIN_OBSERVE;
            end
            default: begin
                timer_d = '0;
                state_d = WIN_OBSERVE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        close = 1'b0;
        unique case (state_q)
            WIN_OBSERVE: close = 1'b0;
            WIN_CLOSE:   close = 1'b1;
            default:     close = 1'b0;
        endcase
    end

    // Independent period checker
    logic [TIMER_W:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)     gap_q <= '0;
        else if (close) gap_q <= '0;
        else            gap_q <= gap_q + 1'b1;
    end

    assert_window_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        close |-> (gap_q == (TIMER_W+1)'(WIN_CYCLES - 1)));
    assert_close_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> !close);

endmodule

// File: rtl/oscmon_classifier.sv
module oscmon_classifier
    import oscmon_pkg::*;
#(
    parameter int         EDGE_MIN   = 4,
    parameter logic [7:0] GLYPH_LO   = 8'h19,
    parameter logic [7:0] GLYPH_HI   = 8'h18,
    parameter logic [7:0] GLYPH_TOG  = 8'h12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic       rise,
    input  logic       close,
    output logic [1:0] status,
    output logic [7:0] glyph
);
    localparam int CNT_W = $clog2(EDGE_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(EDGE_MIN);

    act_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_eff;
    logic             enough;

    assign cnt_eff = {1'b0, cnt_q} + {{CNT_W{1'b0}}, rise};
    assign enough  = (cnt_eff >= (CNT_W+1)'(EDGE_MIN));

    // Edge counter, saturating at the threshold
    always_comb begin
        cnt_d = cnt_q;
        if (close)                        cnt_d = '0;
        else if (rise && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACT_STUCK_LO;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: only at window close
    always_comb begin
        state_d = state_q;
        if (close) begin
            unique case (state_q)
                ACT_STUCK_LO, ACT_STUCK_HI, ACT_TOGGLING: begin
                    if (enough)     state_d = ACT_TOGGLING;
                    else if (level) state_d = ACT_STUCK_HI;
                    else            state_d = ACT_STUCK_LO;
                end
                default: state_d = ACT_STUCK_LO;
            endcase
        end
    end

    // Outputs
    always_comb begin
        status = state_q;
        glyph  = GLYPH_LO;
        unique case (state_q)
            ACT_STUCK_LO: glyph = GLYPH_LO;
            ACT_STUCK_HI: glyph = GLYPH_HI;
            ACT_TOGGLING: glyph = GLYPH_TOG;
            default:      glyph = GLYPH_LO;
        endcase
    end

    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !close |=> $stable(status));
    assert_no_code_11_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);
    assert_toggle_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (close && enough) |=> (status == 2'b10));
    assert_level_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !enough) |=> (status == {1'b0, $past(level)}));

endmodule

// File: rtl/osc_activity_monitor.sv
module osc_activity_monitor
    import oscmon_pkg::*;
#(
    parameter int         WIN_LOG2  = 12,
    parameter int         EDGE_MIN  = 4,
    parameter int         SYNC_FF   = 2,
    parameter logic [7:0] GLYPH_LO  = 8'h19,
    parameter logic [7:0] GLYPH_HI  = 8'h18,
    parameter logic [7:0] GLYPH_TOG = 8'h12
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       osc_a,
    input  logic       osc_b,
    output logic [1:0] stat_a,
    output logic [1:0] stat_b,
    output logic [7:0] glyph_a,
    output logic [7:0] glyph_b
);
    localparam int NUM_CH = 2;

    logic       close;
    logic [NUM_CH-1:0] osc_in, lvl, rise;
    logic [1:0] stat_v  [NUM_CH];
    logic [7:0] glyph_v [NUM_CH];

    assign osc_in = {osc_b, osc_a};

    oscmon_window #(.WIN_LOG2(WIN_LOG2)) u_window (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .close (close)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        oscmon_sync #(.STAGES(SYNC_FF)) u_sync (
            .clk      (clk_ref),
            .rst_n    (rst_n),
            .async_in (osc_in[ch]),
            .level    (lvl[ch]),
            .rise     (rise[ch])
        );
        oscmon_classifier #(
            .EDGE_MIN  (EDGE_MIN),
            .GLYPH_LO  (GLYPH_LO),
            .GLYPH_HI  (GLYPH_HI),
            .GLYPH_TOG (GLYPH_TOG)
        ) u_class (
            .clk    (clk_ref),
            .rst_n  (rst_n),
            .level  (lvl[ch]),
            .rise   (rise[ch]),
            .close  (close),
            .status (stat_v[ch]),
            .glyph  (glyph_v[ch])
        );
    end

    assign stat_a  = stat_v[0];
    assign stat_b  = stat_v[1];
    assign glyph_a = glyph_v[0];
    assign glyph_b = glyph_v[1];

    assert_first_window_low_R6: assert property (@(posedge clk_ref)
        !rst_n |=> (stat_a == 2'b00 && stat_b == 2'b00));
    assert_glyph_pair_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (stat_a == 2'b01) |-> (glyph_a == GLYPH_HI));

endmodule

// File: tb/osc_activity_monitor_bench.sv
module osc_activity_monitor_bench;
    localparam int WL  = 6;
    localparam int WIN = 1 << WL;
    localparam int EMIN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_a = 1'b0, osc_b = 1'b0;
    logic [1:0] stat_a, stat_b;
    logic [7:0] glyph_a, glyph_b;
    int         cyc = 0;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    osc_activity_monitor #(.WIN_LOG2(WL), .EDGE_MIN(EMIN)) u_osc_activity_monitor (
        .clk_ref (clk), .rst_n (rst_n), .osc_a (osc_a), .osc_b (osc_b),
        .stat_a (stat_a), .stat_b (stat_b), .glyph_a (glyph_a), .glyph_b (glyph_b)
    );

    function automatic logic [7:0] glyph_of(input logic [1:0] s);
        return (s == 2'b10) ? 8'h12 : (s == 2'b01) ? 8'h18 : 8'h19;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cycle(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] prev_a, prev_b, exp_a, exp_b;
        int base, nb, fb;
        repeat (4) @(negedge clk);
        check("R6 status_a in reset", {6'b0, stat_a}, 8'h00);
        rst_n = 1'b1;
        wait_cycle(10);
        check("R6 status_a early", {6'b0, stat_a}, 8'h00);
        check("R6 status_b early", {6'b0, stat_b}, 8'h00);
        check("R6 glyph_a early", glyph_a, 8'h19);
        check("R6 glyph_b early", glyph_b, 8'h19);
        osc_a = 1'b1;               // stuck high during first window
        wait_cycle(WIN - 1);
        check("R5 no update before first close", {6'b0, stat_a}, 8'h00);
        wait_cycle(WIN);
        check("R4 stuck high after first window", {6'b0, stat_a}, 8'h01);
        check("R7 up glyph", glyph_a, 8'h18);
        check("R4 stuck low after first window", {6'b0, stat_b}, 8'h00);
        prev_a = 2'b01; prev_b = 2'b00;

        for (int k = 2; k < 16; k++) begin
            int n  = (k - 2) / 2;
            int f  = (k - 2) % 2;
            nb = 6 - n; fb = 1 - f;
            base = (k - 1) * WIN + 2;
            wait_cycle(base);
            osc_a = 1'b0; osc_b = 1'b0;
            for (int i = 0; i < 6; i++) begin
                wait_cycle(base + 2 + 6 * i);
                if (i < n)  osc_a = 1'b1;
                if (i < nb) osc_b = 1'b1;
                wait_cycle(base + 5 + 6 * i);
                osc_a = 1'b0; osc_b = 1'b0;
            end
            wait_cycle(base + 40);
            osc_a = f[0]; osc_b = fb[0];
            exp_a = (n + f >= EMIN) ? 2'b10 : {1'b0, f[0]};
            exp_b = (nb + fb >= EMIN) ? 2'b10 : {1'b0, fb[0]};
            wait_cycle(k * WIN - 1);
            check("R5 hold a before close", {6'b0, stat_a}, {6'b0, prev_a});
            check("R1 hold b before close", {6'b0, stat_b}, {6'b0, prev_b});
            wait_cycle(k * WIN);
            check((exp_a == 2'b10) ? "R3 status_a" : "R4 status_a", {6'b0, stat_a}, {6'b0, exp_a});
            check((exp_b == 2'b10) ? "R3 status_b" : "R4 status_b", {6'b0, stat_b}, {6'b0, exp_b});
            check("R7 glyph_a", glyph_a, glyph_of(exp_a));
            check("R7 glyph_b", glyph_b, glyph_of(exp_b));
            check("R2 no code 11", {7'b0, (stat_a == 2'b11) | (stat_b == 2'b11)}, 8'h00);
            prev_a = exp_a; prev_b = exp_b;
        end

        // R8: a rise driven too late (detected after the close edge) moves to next window
        base = 15 * WIN + 2;
        wait_cycle(base);
        osc_a = 1'b0; osc_b = 1'b0;
        for (int i = 0; i < 3; i++) begin
            wait_cycle(base + 2 + 6 * i); osc_a = 1'b1;
            wait_cycle(base + 5 + 6 * i); osc_a = 1'b0;
        end
        wait_cycle(16 * WIN - 2);   // rise seen by edge detect after posedge 16*WIN
        osc_a = 1'b1;
        wait_cycle(16 * WIN);
        check("R8 late edge not counted", {6'b0, stat_a}, 8'h00);
        wait_cycle(17 * WIN);
        check("R8 late edge lands in next window", {6'b0, stat_a}, 8'h01);
        finish_run();
    end
endmodule